// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Port Controller

This block is the test access port of a device that offers boundary scan in a reduced form. A serial master drives a test clock, a mode-select line and a serial data input. A sixteen-state machine follows the mode-select line. Through that state machine the master loads a three-bit instruction and then scans one of three data registers: a single-bit bypass cell, a 32-bit identification register, or an 84-bit boundary register. The identification register is loaded from a hardwired value. The boundary register is loaded from a parallel snapshot of the device pins.

The controller never drives pins from the scan chain. The instructions that a full implementation would use to preload or drive pins only capture the snapshot here, and Update-DR leaves everything as it was. Two of the boundary instructions also raise a request that the host place its data outputs in high impedance. Instruction codes with no defined use fall back to the bypass cell, so the serial chain through the device always stays continuous.

Top module: `scan_tap_top`

## Requirements
- R1: Mode-select and serial input are sampled on the rising test-clock edge. The serial output and its enable change only on the falling edge. The enable is 1 only while the state is Shift-IR or Shift-DR.
- R2: Five consecutive rising edges with mode-select high reach Test-Logic-Reset from any state. A low level on the active-low power-on reset forces that state asynchronously.
- R3: In Test-Logic-Reset the active instruction becomes 001, which is the identification instruction.
- R4: Capture-IR loads the instruction shift register with binary 001, so its two low bits read 01. The bits then shift out low bit first.
- R5: The active instruction changes only when the state machine leaves Update-IR. The high-impedance request follows the active instruction and does not follow the bits being shifted in.
- R6: Under instruction 001, Capture-DR loads the 32-bit identification value with bit 0 forced to 1.
- R7: Codes 000, 010 and 100 select the 84-bit boundary register. It captures the pin snapshot, except that placeholder cells capture 0. By default the placeholder cells are bits 40 and 80 to 83.
- R8: The high-impedance request is 1 while the active instruction is 000 or 010, and 0 for every other code.
- R9: Update-DR has no effect. Data shifted into the boundary register is not applied anywhere, and the next capture again returns the pin snapshot.
- R10: Codes 011, 101, 110 and 111 select the one-bit bypass register, which captures 0.
- R11: Each data register shifts with the serial input entering at its MSB and its LSB leaving on the serial output. A bit shifted in therefore appears on the output after exactly as many shifts as the register is long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| porN | input | 1 | Active-low asynchronous power-on reset |
| tms | input | 1 | Mode select, steers the state machine |
| tdi | input | 1 | Serial data input |
| pinSnap | input | 84 | Parallel snapshot of the device pins |
| idValue | input | 32 | Hardwired identification value |
| tdo | output | 1 | Serial data output, updated on the falling edge |
| tdoEn | output | 1 | Output enable for tdo, high only in the shift states |
| outHiZReq | output | 1 | Request to the host to float its data outputs |

## Verification
The hardest case to reach is a state in which the shifted instruction and the active instruction disagree. This happens in the middle of Shift-IR, in Exit1-IR and in Update-IR, and the high-impedance request must still follow the old code there. The stimulus stops a boundary instruction partway through an instruction shift and samples the request at each of these states before it lets the update take place. Reset by five mode-select edges is reached from random walks through the state graph, including walks that end in the pause states. A boundary instruction is loaded before each walk so that a missed reset shows on the request line.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PS_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PS_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {SRC_BYP, SRC_ID, SRC_BSR} drSel_e;

  typedef struct packed {
    logic   captureDr;
    logic   shiftDr;
    logic   shiftIr;
    drSel_e drSel;
  } tapStrobe_t;

  localparam logic [IR_W-1:0] OP_DRIVE  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
  localparam logic [IR_W-1:0] OP_FLOAT  = 3'b010;
  localparam logic [IR_W-1:0] OP_SNAP   = 3'b100;
  localparam logic [IR_W-1:0] IR_CAPVAL = 3'b001;

  function automatic tapState_e nextState(input tapState_e cur, input logic m);
    tapState_e nxt;
    unique case (cur)
      ST_RESET:  nxt = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = m ? ST_UPD_DR : ST_PS_DR;
      ST_PS_DR:  nxt = m ? ST_EX2_DR : ST_PS_DR;
      ST_EX2_DR: nxt = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = m ? ST_UPD_IR : ST_PS_IR;
      ST_PS_IR:  nxt = m ? ST_EX2_IR : ST_PS_IR;
      ST_EX2_IR: nxt = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = m ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       porN,
  input  logic       tms,
  input  logic       tdi,
  output tapState_e  state,
  output tapStrobe_t strobe,
  output logic       irLsb,
  output logic       hiZReq
);

  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irActive;
  drSel_e          drSel;

  // state machine plus instruction shift and active registers
  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      state    <= ST_RESET;
      irShift  <= IR_CAPVAL;
      irActive <= OP_IDENT;
    end else begin
      state <= nextState(state, tms);
      if (state == ST_CAP_IR) begin
        irShift <= IR_CAPVAL;
      end else if (state == ST_SH_IR) begin
        irShift <= {tdi, irShift[IR_W-1:1]};
      end
      if (state == ST_RESET) begin
        irActive <= OP_IDENT;
      end else if (state == ST_UPD_IR) begin
        irActive <= irShift;
      end
    end
  end

  // instruction decode: unused codes fall back to bypass
  always_comb begin
    hiZReq = 1'b0;
    drSel  = SRC_BYP;
    case (irActive)
      OP_DRIVE: begin drSel = SRC_BSR; hiZReq = 1'b1; end
      OP_FLOAT: begin drSel = SRC_BSR; hiZReq = 1'b1; end
      OP_SNAP:  drSel = SRC_BSR;
      OP_IDENT: drSel = SRC_ID;
      default:  drSel = SRC_BYP;
    endcase
  end

  assign irLsb            = irShift[0];
  assign strobe.captureDr = (state == ST_CAP_DR);
  assign strobe.shiftDr   = (state == ST_SH_DR);
  assign strobe.shiftIr   = (state == ST_SH_IR);
  assign strobe.drSel     = drSel;

endmodule

// File: rtl/scan_tap_dpath.sv
module scan_tap_dpath
  import scan_tap_pkg::*;
#(
  parameter int               ID_W    = 32,
  parameter int               BSR_W   = 84,
  parameter logic [BSR_W-1:0] PH_MASK = '0
) (
  input  logic             tck,
  input  logic             porN,
  input  logic             tdi,
  input  tapStrobe_t       strobe,
  input  logic             irLsb,
  input  logic [BSR_W-1:0] pinSnap,
  input  logic [ID_W-1:0]  idValue,
  output logic             tdo,
  output logic             tdoEn
);

  localparam logic [ID_W-1:0] PRESENCE = ID_W'(1);

  logic             bypReg;
  logic [ID_W-1:0]  idReg;
  logic [BSR_W-1:0] bsrReg;
  logic [BSR_W-1:0] bsrSnap;
  logic             drLsb;

  assign bsrSnap = pinSnap & ~PH_MASK;

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      bypReg <= 1'b0;
      idReg  <= '0;
      bsrReg <= '0;
    end else if (strobe.captureDr) begin
      case (strobe.drSel)
        SRC_ID:  idReg  <= idValue | PRESENCE;
        SRC_BSR: bsrReg <= bsrSnap;
        default: bypReg <= 1'b0;
      endcase
    end else if (strobe.shiftDr) begin
      case (strobe.drSel)
        SRC_ID:  idReg  <= {tdi, idReg[ID_W-1:1]};
        SRC_BSR: bsrReg <= {tdi, bsrReg[BSR_W-1:1]};
        default: bypReg <= tdi;
      endcase
    end
  end

  always_comb begin
    case (strobe.drSel)
      SRC_ID:  drLsb = idReg[0];
      SRC_BSR: drLsb = bsrReg[0];
      default: drLsb = bypReg;
    endcase
  end

  // serial output launched on the falling edge
  always_ff @(negedge tck or negedge porN) begin
    if (!porN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strobe.shiftDr | strobe.shiftIr;
      tdo   <= strobe.shiftIr ? irLsb : drLsb;
    end
  end

endmodule

// File: rtl/scan_tap_top.sv
module scan_tap_top
  import scan_tap_pkg::*;
#(
  parameter int               ID_W    = 32,
  parameter int               BSR_W   = 84,
  parameter logic [BSR_W-1:0] PH_MASK = {4'hF, 39'd0, 1'b1, 40'd0}
) (
  input  logic             tck,
  input  logic             porN,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pinSnap,
  input  logic [ID_W-1:0]  idValue,
  output logic             tdo,
  output logic             tdoEn,
  output logic             outHiZReq
);

  tapState_e  ctlState;
  tapStrobe_t strobe;
  logic       irLsb;

  scan_tap_ctrl ctrl_i (
    .tck    (tck),
    .porN   (porN),
    .tms    (tms),
    .tdi    (tdi),
    .state  (ctlState),
    .strobe (strobe),
    .irLsb  (irLsb),
    .hiZReq (outHiZReq)
  );

  scan_tap_dpath #(
    .ID_W    (ID_W),
    .BSR_W   (BSR_W),
    .PH_MASK (PH_MASK)
  ) dpath_i (
    .tck     (tck),
    .porN    (porN),
    .tdi     (tdi),
    .strobe  (strobe),
    .irLsb   (irLsb),
    .pinSnap (pinSnap),
    .idValue (idValue),
    .tdo     (tdo),
    .tdoEn   (tdoEn)
  );

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
(
  input logic      tck,
  input logic      porN,
  input logic      tms,
  input logic      tdoEn,
  input logic      outHiZReq,
  input tapState_e state
);

  logic [2:0] onesCnt;
  logic       armed;

  always_ff @(posedge tck or negedge porN) begin
    if (!porN) begin
      onesCnt <= '0;
      armed   <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (!tms)                onesCnt <= '0;
      else if (onesCnt != 3'd7) onesCnt <= onesCnt + 3'd1;
    end
  end

  a_r1_tdoen_shift: assert property (@(posedge tck) disable iff (!porN)
    tdoEn |-> (state == ST_SH_DR || state == ST_SH_IR));

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!porN)
    (onesCnt >= 3'd5) |-> (state == ST_RESET));

  a_r3_reset_ident: assert property (@(posedge tck) disable iff (!porN)
    (state == ST_RESET) |=> !outHiZReq);

  a_r5_hiz_on_update: assert property (@(posedge tck) disable iff (!porN)
    (armed && !$stable(outHiZReq)) |->
      ($past(state) == ST_UPD_IR || $past(state) == ST_RESET));

endmodule

bind scan_tap_top scan_tap_chk chk_i (
  .tck       (tck),
  .porN      (porN),
  .tms       (tms),
  .tdoEn     (tdoEn),
  .outHiZReq (outHiZReq),
  .state     (ctlState)
);

// File: tb/scan_tap_top_tb_top.sv
`timescale 1ns/1ps
module scan_tap_top_tb_top;

  localparam int BSR_W = 84;
  localparam int ID_W  = 32;
  localparam logic [BSR_W-1:0] PH = {4'hF, 39'd0, 1'b1, 40'd0};

  logic             tck = 1'b0;
  logic             porN = 1'b0;
  logic             tms = 1'b1;
  logic             tdi = 1'b0;
  logic [BSR_W-1:0] pinSnap = '0;
  logic [ID_W-1:0]  idValue = 32'h1234_5676;
  logic             tdo, tdoEn, outHiZReq;

  int nChecks = 0;
  int nBad = 0;
  bit r1Bad = 0;
  logic lastEn;
  logic firstEn;

  always #5 tck = ~tck;

  scan_tap_top dut_i (
    .tck(tck), .porN(porN), .tms(tms), .tdi(tdi),
    .pinSnap(pinSnap), .idValue(idValue),
    .tdo(tdo), .tdoEn(tdoEn), .outHiZReq(outHiZReq)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one test clock: sample outputs after the falling edge, drive, cross the rising edge
  task automatic tick(input logic m, input logic d, output logic o);
    @(negedge tck); #2;
    o = tdo;
    lastEn = tdoEn;
    tms = m;
    tdi = d;
    @(posedge tck); #1;
    if (tdo !== o) r1Bad = 1;
  endtask

  task automatic go(input logic m);
    logic o;
    tick(m, 1'b0, o);
  endtask

  task automatic loadIr(input logic [2:0] code, output logic [2:0] capt);
    logic o;
    go(1); go(1); go(0); go(0);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i], o);
      capt[i] = o;
    end
    go(1); go(0);
  endtask

  task automatic scanDr(input int n, input logic [127:0] din, output logic [127:0] dout);
    logic o;
    dout = '0;
    go(1); go(0); go(0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o);
      if (i == 0) firstEn = lastEn;
      dout[i] = o;
    end
    go(1); go(0);
  endtask

  function automatic int drLen(input logic [2:0] c);
    if (c == 3'b000 || c == 3'b010 || c == 3'b100) return BSR_W;
    if (c == 3'b001) return ID_W;
    return 1;
  endfunction

  function automatic logic [127:0] capVal(input logic [2:0] c);
    if (c == 3'b000 || c == 3'b010 || c == 3'b100) return 128'(pinSnap & ~PH);
    if (c == 3'b001) return 128'(idValue | 32'd1);
    return '0;
  endfunction

  function automatic logic [127:0] expScan(input int len, input logic [127:0] cap,
                                           input logic [127:0] din, input int n);
    logic [127:0] r = '0;
    for (int i = 0; i < n; i++) begin
      if (i < len) r[i] = cap[i];
      else         r[i] = din[i - len];
    end
    return r;
  endfunction

  function automatic string tagOf(input logic [2:0] c);
    if (c == 3'b001) return "R6";
    if (c == 3'b000 || c == 3'b010 || c == 3'b100) return "R7";
    return "R10";
  endfunction

  task automatic runCode(input logic [2:0] c);
    logic [2:0]   capt;
    logic [127:0] din, dout;
    int n;
    din = {$urandom, $urandom, $urandom, $urandom};
    loadIr(c, capt);
    chk("R8 hiz request for code", 128'(outHiZReq), 128'(c == 3'b000 || c == 3'b010));
    n = drLen(c) + 12;
    scanDr(n, din, dout);
    chk({tagOf(c), " R11 scan out"}, dout, expScan(drLen(c), capVal(c), din, n));
  endtask

  task automatic randomize5(input int steps);
    for (int j = 0; j < steps; j++) go(1'($urandom % 2));
    for (int j = 0; j < 5; j++) go(1);
    go(0);
  endtask

  initial begin
    logic [2:0]   capt;
    logic [127:0] din, dout, pA;
    void'($urandom(32'd4711));

    repeat (3) @(posedge tck);
    #2;
    chk("R1 tdoEn low in reset", 128'(tdoEn), 128'(0));
    chk("R3 no hiz at reset", 128'(outHiZReq), 128'(0));
    @(negedge tck); #1 porN = 1'b1;

    go(0);
    chk("R1 tdoEn low in idle", 128'(tdoEn), 128'(0));

    din = {$urandom, $urandom, $urandom, $urandom};
    scanDr(ID_W + 8, din, dout);
    chk("R3 R6 ident after power-on", dout, expScan(ID_W, capVal(3'b001), din, ID_W + 8));
    chk("R1 tdoEn high in shift", 128'(firstEn), 128'(1));

    loadIr(3'b111, capt);
    chk("R4 capture-ir pattern", 128'(capt), 128'(3'b001));

    // every code once, then random codes
    for (int c = 0; c < 8; c++) begin
      pinSnap = {$urandom, $urandom, $urandom};
      idValue = $urandom;
      runCode(3'(c));
    end
    for (int k = 0; k < 16; k++) begin
      pinSnap = {$urandom, $urandom, $urandom};
      idValue = $urandom;
      runCode(3'($urandom % 8));
    end

    // R9: shifted boundary data is not applied
    pinSnap = {$urandom, $urandom, $urandom};
    loadIr(3'b100, capt);
    din = 128'(~pinSnap);
    scanDr(BSR_W, din, dout);
    chk("R9 no hiz after update-dr", 128'(outHiZReq), 128'(0));
    pA = {$urandom, $urandom, $urandom, $urandom};
    scanDr(BSR_W, pA, dout);
    chk("R9 recapture returns snapshot", dout, capVal(3'b100));

    // R5: request follows active code, not the shifted one
    begin
      logic o;
      go(1); go(1); go(0); go(0);
      tick(0, 0, o); tick(0, 0, o);
      chk("R5 hiz unchanged mid shift-ir", 128'(outHiZReq), 128'(0));
      tick(1, 0, o);
      chk("R5 hiz unchanged in exit1-ir", 128'(outHiZReq), 128'(0));
      go(1);
      chk("R5 hiz unchanged in update-ir", 128'(outHiZReq), 128'(0));
      go(0);
      chk("R5 hiz follows new code", 128'(outHiZReq), 128'(1));
    end

    // R2: five high edges from random states
    for (int t = 0; t < 6; t++) begin
      loadIr(3'b010, capt);
      randomize5(1 + int'($urandom % 20));
      chk("R2 R3 hiz cleared by tms reset", 128'(outHiZReq), 128'(0));
      din = {$urandom, $urandom, $urandom, $urandom};
      scanDr(ID_W + 4, din, dout);
      chk("R2 R3 ident after tms reset", dout, expScan(ID_W, capVal(3'b001), din, ID_W + 4));
    end
    loadIr(3'b000, capt);
    go(1); go(1); go(0); go(0); go(1); go(0);
    for (int j = 0; j < 5; j++) go(1);
    go(0);
    chk("R2 reset from pause-ir", 128'(outHiZReq), 128'(0));

    // R2: asynchronous power-on reset mid shift
    loadIr(3'b000, capt);
    go(1); go(0); go(0);
    @(negedge tck); #3 porN = 1'b0;
    #2;
    chk("R2 async reset clears hiz", 128'(outHiZReq), 128'(0));
    chk("R1 async reset clears tdoEn", 128'(tdoEn), 128'(0));
    @(negedge tck); #1 porN = 1'b1;
    go(0);
    din = {$urandom, $urandom, $urandom, $urandom};
    scanDr(ID_W + 4, din, dout);
    chk("R3 ident after async reset", dout, expScan(ID_W, capVal(3'b001), din, ID_W + 4));

    chk("R1 tdo steady across rising edges", 128'(r1Bad), 128'(0));

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    #1_500_000;
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule